// File: doc/BRIEF.md
# Handshaked Bit-Serial Word Transceiver

This block carries one data word at a time over a serial link between a storage drive and its host controller. There is one data line in each direction and a shared shift strobe. Bits travel most significant first. A word is 12 or 8 bits wide. A command sequencer above the block asks for one word per request, either a transmit or a receive. It may ask for a handshaked word. Such a word pauses on a transfer-request line until the controller answers with a rising edge on its RUN line.

The RUN and INIT lines pass through a synchroniser. Their rising edges are kept in sticky flags, so an edge that arrives before the block waits for it is not lost. A pending INIT edge stops any word in progress and refuses new ones until the sequencer clears the flag. The time unit that sets every bit phase is a parameter counted in clock cycles.

Top module: `serial_word_xcvr`

## Requirements
- R1: Bits are shifted most significant first. With `req_wsel_i` = 00 the word is 12 bits wide when `mode12_i` is high and 8 bits wide otherwise. An 8-bit word uses `req_data_i[7:0]` and returns its data in `rsp_data_o[7:0]` with the upper four bits zero.
- R2: The width can be chosen in three other ways. `req_wsel_i` = 01 forces 8 bits. `req_wsel_i` = 10 forces 12 bits. `req_wsel_i` = 11 gives 12 bits when `dma_i` or `mode12_i` is high and 8 bits otherwise. The width is sampled when the request is accepted.
- R3: A transmit begins with `out_o` high for 3 units before the first bit. Each bit then drives `datao_o` to the bit value for a 2-unit setup phase, followed by 1 unit with `shift_o` high while `datao_o` holds that bit.
- R4: After the last transmitted bit, `datao_o` keeps that bit for 3 more units and then returns low. `out_o` falls only when the handshake, if one was requested, has completed.
- R5: A receive first spends one cycle with `done_clr_o` high and `out_o`, `datao_o` and `shift_o` low. For each bit, `datai_i` is sampled at the last cycle of the 2-unit setup phase, just before the 1-unit `shift_o` pulse.
- R6: In a handshaked word, `trq_o` rises before the first bit on a receive and after the tail on a transmit. It stays high until a RUN rising edge is seen. It falls on the fourth rising clock edge after `run_i` goes high.
- R7: A RUN rising edge seen while no handshake is waiting is held. The next handshake then completes after one cycle of `trq_o`. Completing the handshake consumes the held edge.
- R8: A rising edge on `init_i` sets `init_pend_o` and aborts a word in progress. The block is idle with `rsp_valid_o` and `rsp_abort_o` high on the fourth clock edge after `init_i` rises. While the flag is set, a new request is answered at once with an abort. `init_clr_i` clears the flag.
- R9: When a word completes, `rsp_valid_o` is high for exactly one cycle, with `rsp_abort_o` low and `busy_o` low. `rsp_data_o` then carries the received word for a receive, and zero for a transmit or an abort.
- R10: A request made while `busy_o` is high is ignored and leaves the word in progress unchanged.
- R11: After reset all outputs are low and no RUN or INIT edge is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start one word (accepted when idle) |
| req_tx_i | input | 1 | 1 = transmit, 0 = receive |
| req_hs_i | input | 1 | 1 = use the request/RUN handshake |
| req_wsel_i | input | 2 | Width choice: 00 mode pin, 01 narrow, 10 wide, 11 command rule |
| req_data_i | input | 12 | Word to transmit |
| mode12_i | input | 1 | Link runs in 12-bit mode |
| dma_i | input | 1 | Controller is in DMA mode |
| run_i | input | 1 | Controller RUN line (asynchronous) |
| init_i | input | 1 | Controller INIT line (asynchronous) |
| init_clr_i | input | 1 | Clear the pending INIT flag |
| datai_i | input | 1 | Serial data from the controller |
| busy_o | output | 1 | A word is in progress |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_abort_o | output | 1 | The completing word was aborted |
| rsp_data_o | output | 12 | Received word |
| init_pend_o | output | 1 | An INIT edge is pending |
| datao_o | output | 1 | Serial data to the controller |
| shift_o | output | 1 | Shift strobe |
| out_o | output | 1 | Transmit direction bracket |
| trq_o | output | 1 | Transfer request |
| done_clr_o | output | 1 | Pulse telling the sequencer to drop its done and error lines |

## Verification
The hardest case to reach is a RUN or INIT edge that lands at a chosen point in a word, because both lines pass through the synchroniser before they take effect. The stimulus counts cycles from the accepted request. It raises `run_i` or `init_i` at a fixed sample index: inside the request wait, in the middle of a transmit's bit phases, or well before any handshake, which leaves the edge pending. The reference waveform is then cut or stretched at the cycle that follows from the synchroniser latency stated in R6 and R8. A second handshake after the pending-edge case confirms that the held edge was consumed.

// File: rtl/sxw_pkg.sv
package sxw_pkg;

   // Phases of one word; the encoding is internal to the transceiver
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_PREP   = 3'd1,
      PH_REQ    = 3'd2,
      PH_LEAD   = 3'd3,
      PH_SETUP  = 3'd4,
      PH_STROBE = 3'd5,
      PH_TAIL   = 3'd6
   } phase_e;

   // Width choice carried on the request
   typedef enum logic [1:0] {
      WS_MODE   = 2'b00,
      WS_NARROW = 2'b01,
      WS_WIDE   = 2'b10,
      WS_CMD    = 2'b11
   } wsel_e;

endpackage

// File: rtl/sxw_edge_catch.sv
// Synchroniser, rising-edge detector and sticky flag for one async line.
module sxw_edge_catch #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   input  logic clr_i,
   output logic flag_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sxw_edge_catch: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] pipe_q;
   logic            rise;
   logic            flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-1:0], sig_i};
   end

   // edge taken after the last synchronising stage
   assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

   // a new edge wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (rise)  flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R7
   edge_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> flag_q);

endmodule

// File: rtl/sxw_phase_timer.sv
// Down counter timing one phase; expire_o marks the phase's last cycle.
module sxw_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             expire_o
);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("sxw_phase_timer: CNT_W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/sxw_bit_shifter.sv
// Holds the outgoing word, collects the incoming one and tracks the bit index.
module sxw_bit_shifter #(
   parameter int WORD_W = 12,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic [IDX_W-1:0]  top_idx_i,
   input  logic              advance_i,
   input  logic              capture_i,
   input  logic              datai_i,
   output logic              bit_o,
   output logic              last_o,
   output logic [WORD_W-1:0] word_o
);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("sxw_bit_shifter: WORD_W must be at least 2");
      end
      if ((1 << IDX_W) < WORD_W) begin : g_bad_idx
         $error("sxw_bit_shifter: IDX_W too small for WORD_W");
      end
   endgenerate

   logic [WORD_W-1:0] tx_q;
   logic [WORD_W-1:0] rx_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q  <= '0;
         rx_q  <= '0;
         idx_q <= '0;
      end else if (load_i) begin
         tx_q  <= data_i;
         rx_q  <= '0;
         idx_q <= top_idx_i;
      end else begin
         if (advance_i) idx_q <= idx_q - 1'b1;
         if (capture_i) rx_q  <= {rx_q[WORD_W-2:0], datai_i};
      end
   end

   assign bit_o  = tx_q[idx_q];
   assign last_o = (idx_q == '0);
   assign word_o = rx_q;

   // R1
   idx_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(idx_q) < WORD_W);

endmodule

// File: rtl/sxw_xfer_ctrl.sv
// Phase sequencer for one word, plus the line and response registers.
module sxw_xfer_ctrl
   import sxw_pkg::*;
#(
   parameter int WIDE_W     = 12,
   parameter int NARROW_W   = 8,
   parameter int IDX_W      = 4,
   parameter int CNT_W      = 4,
   parameter int LEAD_CYC   = 12,
   parameter int SETUP_CYC  = 8,
   parameter int STROBE_CYC = 4,
   parameter int TAIL_CYC   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic              req_tx_i,
   input  logic              req_hs_i,
   input  logic [1:0]        req_wsel_i,
   input  logic              mode12_i,
   input  logic              dma_i,
   input  logic              run_flag_i,
   input  logic              init_flag_i,
   input  logic              tmr_expire_i,
   input  logic              bit_i,
   input  logic              last_bit_i,
   input  logic [WIDE_W-1:0] word_i,
   output logic              tmr_load_o,
   output logic [CNT_W-1:0]  tmr_val_o,
   output logic              sh_load_o,
   output logic [IDX_W-1:0]  sh_top_o,
   output logic              sh_advance_o,
   output logic              sh_capture_o,
   output logic              run_clr_o,
   output logic              busy_o,
   output logic              rsp_valid_o,
   output logic              rsp_abort_o,
   output logic [WIDE_W-1:0] rsp_data_o,
   output logic              datao_o,
   output logic              shift_o,
   output logic              out_o,
   output logic              trq_o,
   output logic              done_clr_o
);

   localparam logic [CNT_W-1:0] LEAD_V   = CNT_W'(LEAD_CYC - 1);
   localparam logic [CNT_W-1:0] SETUP_V  = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] STROBE_V = CNT_W'(STROBE_CYC - 1);
   localparam logic [CNT_W-1:0] TAIL_V   = CNT_W'(TAIL_CYC - 1);
   localparam logic [IDX_W-1:0] WIDE_TOP   = IDX_W'(WIDE_W - 1);
   localparam logic [IDX_W-1:0] NARROW_TOP = IDX_W'(NARROW_W - 1);

   phase_e phase_q, phase_d;
   logic   tx_q, tx_d;
   logic   hs_q, hs_d;
   logic   finish, abort;
   logic   wide_sel;
   logic   rsp_valid_q, rsp_abort_q;
   logic [WIDE_W-1:0] rsp_data_q;

   // width decision at request time
   always_comb begin
      unique case (wsel_e'(req_wsel_i))
         WS_MODE:   wide_sel = mode12_i;
         WS_NARROW: wide_sel = 1'b0;
         WS_WIDE:   wide_sel = 1'b1;
         default:   wide_sel = mode12_i | dma_i;
      endcase
   end

   assign sh_top_o = wide_sel ? WIDE_TOP : NARROW_TOP;

   always_comb begin
      phase_d      = phase_q;
      tx_d         = tx_q;
      hs_d         = hs_q;
      tmr_load_o   = 1'b0;
      tmr_val_o    = '0;
      sh_load_o    = 1'b0;
      sh_advance_o = 1'b0;
      sh_capture_o = 1'b0;
      run_clr_o    = 1'b0;
      finish       = 1'b0;
      abort        = 1'b0;
      if (phase_q == PH_IDLE) begin
         if (req_valid_i) begin
            if (init_flag_i) begin
               abort = 1'b1;
            end else begin
               sh_load_o = 1'b1;
               tx_d      = req_tx_i;
               hs_d      = req_hs_i;
               if (req_tx_i) begin
                  phase_d    = PH_LEAD;
                  tmr_load_o = 1'b1;
                  tmr_val_o  = LEAD_V;
               end else begin
                  phase_d = PH_PREP;
               end
            end
         end
      end else if (init_flag_i) begin
         abort   = 1'b1;
         phase_d = PH_IDLE;
      end else begin
         unique case (phase_q)
            PH_PREP: begin
               if (hs_q) begin
                  phase_d = PH_REQ;
               end else begin
                  phase_d    = PH_SETUP;
                  tmr_load_o = 1'b1;
                  tmr_val_o  = SETUP_V;
               end
            end
            PH_REQ: begin
               if (run_flag_i) begin
                  run_clr_o = 1'b1;
                  if (tx_q) begin
                     finish  = 1'b1;
                     phase_d = PH_IDLE;
                  end else begin
                     phase_d    = PH_SETUP;
                     tmr_load_o = 1'b1;
                     tmr_val_o  = SETUP_V;
                  end
               end
            end
            PH_LEAD: begin
               if (tmr_expire_i) begin
                  phase_d    = PH_SETUP;
                  tmr_load_o = 1'b1;
                  tmr_val_o  = SETUP_V;
               end
            end
            PH_SETUP: begin
               if (tmr_expire_i) begin
                  phase_d      = PH_STROBE;
                  tmr_load_o   = 1'b1;
                  tmr_val_o    = STROBE_V;
                  sh_capture_o = ~tx_q;
               end
            end
            PH_STROBE: begin
               if (tmr_expire_i) begin
                  if (!last_bit_i) begin
                     sh_advance_o = 1'b1;
                     phase_d      = PH_SETUP;
                     tmr_load_o   = 1'b1;
                     tmr_val_o    = SETUP_V;
                  end else if (tx_q) begin
                     phase_d    = PH_TAIL;
                     tmr_load_o = 1'b1;
                     tmr_val_o  = TAIL_V;
                  end else begin
                     finish  = 1'b1;
                     phase_d = PH_IDLE;
                  end
               end
            end
            PH_TAIL: begin
               if (tmr_expire_i) begin
                  if (hs_q) begin
                     phase_d = PH_REQ;
                  end else begin
                     finish  = 1'b1;
                     phase_d = PH_IDLE;
                  end
               end
            end
            default: phase_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         tx_q        <= 1'b0;
         hs_q        <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_abort_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         phase_q     <= phase_d;
         tx_q        <= tx_d;
         hs_q        <= hs_d;
         rsp_valid_q <= finish | abort;
         rsp_abort_q <= abort;
         rsp_data_q  <= (finish && !tx_q) ? word_i : '0;
      end
   end

   // line decodes from registered phase
   assign busy_o      = (phase_q != PH_IDLE);
   assign shift_o     = (phase_q == PH_STROBE);
   assign trq_o       = (phase_q == PH_REQ);
   assign done_clr_o  = (phase_q == PH_PREP);
   assign out_o       = tx_q & busy_o;
   assign datao_o     = tx_q & bit_i &
                        ((phase_q == PH_SETUP) || (phase_q == PH_STROBE) ||
                         (phase_q == PH_TAIL));
   assign rsp_valid_o = rsp_valid_q;
   assign rsp_abort_o = rsp_abort_q;
   assign rsp_data_o  = rsp_data_q;

   // R3
   setup_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_STROBE && $past(phase_q) == PH_SETUP) |-> $past(tmr_expire_i));

   // R5
   prep_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_clr_o |=> !done_clr_o);

   // R6
   req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(trq_o) |-> ($past(run_flag_i) || $past(init_flag_i)));

   // R8
   init_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && init_flag_i) |=> (!busy_o && rsp_valid_o && rsp_abort_o));

   // R9
   done_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && !rsp_abort_o) |-> ($past(busy_o) && !busy_o));

endmodule

// File: rtl/serial_word_xcvr.sv
// Top: one handshaked bit-serial word per request.
module serial_word_xcvr #(
   parameter int UNIT_CYC    = 4,
   parameter int WIDE_W      = 12,
   parameter int NARROW_W    = 8,
   parameter int SYNC_STAGES = 2,
   parameter int LEAD_UNITS  = 3,
   parameter int SETUP_UNITS = 2,
   parameter int TAIL_UNITS  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic              req_tx_i,
   input  logic              req_hs_i,
   input  logic [1:0]        req_wsel_i,
   input  logic [WIDE_W-1:0] req_data_i,
   input  logic              mode12_i,
   input  logic              dma_i,
   input  logic              run_i,
   input  logic              init_i,
   input  logic              init_clr_i,
   input  logic              datai_i,
   output logic              busy_o,
   output logic              rsp_valid_o,
   output logic              rsp_abort_o,
   output logic [WIDE_W-1:0] rsp_data_o,
   output logic              init_pend_o,
   output logic              datao_o,
   output logic              shift_o,
   output logic              out_o,
   output logic              trq_o,
   output logic              done_clr_o
);

   localparam int LEAD_CYC   = LEAD_UNITS * UNIT_CYC;
   localparam int SETUP_CYC  = SETUP_UNITS * UNIT_CYC;
   localparam int STROBE_CYC = UNIT_CYC;
   localparam int TAIL_CYC   = TAIL_UNITS * UNIT_CYC;
   localparam int MAX_A      = (LEAD_CYC > SETUP_CYC) ? LEAD_CYC : SETUP_CYC;
   localparam int MAX_CYC    = (MAX_A > TAIL_CYC) ? MAX_A : TAIL_CYC;
   localparam int CNT_W      = $clog2(MAX_CYC + 1);
   localparam int IDX_W      = $clog2(WIDE_W);

   generate
      if (UNIT_CYC < 1) begin : g_bad_unit
         $error("serial_word_xcvr: UNIT_CYC must be at least 1");
      end
      if (NARROW_W < 1 || NARROW_W > WIDE_W) begin : g_bad_narrow
         $error("serial_word_xcvr: NARROW_W must lie in 1..WIDE_W");
      end
      if (LEAD_UNITS < 1 || SETUP_UNITS < 1 || TAIL_UNITS < 1) begin : g_bad_units
         $error("serial_word_xcvr: phase lengths must be at least one unit");
      end
   endgenerate

   logic run_flag, init_flag, run_clr;
   logic tmr_load, tmr_expire;
   logic [CNT_W-1:0] tmr_val;
   logic sh_load, sh_advance, sh_capture, sh_bit, sh_last;
   logic [IDX_W-1:0]  sh_top;
   logic [WIDE_W-1:0] sh_word;

   sxw_edge_catch #(.STAGES(SYNC_STAGES)) u_run_catch (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (run_i),
      .clr_i  (run_clr),
      .flag_o (run_flag)
   );

   sxw_edge_catch #(.STAGES(SYNC_STAGES)) u_init_catch (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (init_i),
      .clr_i  (init_clr_i),
      .flag_o (init_flag)
   );

   sxw_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (tmr_load),
      .val_i    (tmr_val),
      .expire_o (tmr_expire)
   );

   sxw_bit_shifter #(.WORD_W(WIDE_W), .IDX_W(IDX_W)) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (sh_load),
      .data_i    (req_data_i),
      .top_idx_i (sh_top),
      .advance_i (sh_advance),
      .capture_i (sh_capture),
      .datai_i   (datai_i),
      .bit_o     (sh_bit),
      .last_o    (sh_last),
      .word_o    (sh_word)
   );

   sxw_xfer_ctrl #(
      .WIDE_W     (WIDE_W),
      .NARROW_W   (NARROW_W),
      .IDX_W      (IDX_W),
      .CNT_W      (CNT_W),
      .LEAD_CYC   (LEAD_CYC),
      .SETUP_CYC  (SETUP_CYC),
      .STROBE_CYC (STROBE_CYC),
      .TAIL_CYC   (TAIL_CYC)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid_i),
      .req_tx_i     (req_tx_i),
      .req_hs_i     (req_hs_i),
      .req_wsel_i   (req_wsel_i),
      .mode12_i     (mode12_i),
      .dma_i        (dma_i),
      .run_flag_i   (run_flag),
      .init_flag_i  (init_flag),
      .tmr_expire_i (tmr_expire),
      .bit_i        (sh_bit),
      .last_bit_i   (sh_last),
      .word_i       (sh_word),
      .tmr_load_o   (tmr_load),
      .tmr_val_o    (tmr_val),
      .sh_load_o    (sh_load),
      .sh_top_o     (sh_top),
      .sh_advance_o (sh_advance),
      .sh_capture_o (sh_capture),
      .run_clr_o    (run_clr),
      .busy_o       (busy_o),
      .rsp_valid_o  (rsp_valid_o),
      .rsp_abort_o  (rsp_abort_o),
      .rsp_data_o   (rsp_data_o),
      .datao_o      (datao_o),
      .shift_o      (shift_o),
      .out_o        (out_o),
      .trq_o        (trq_o),
      .done_clr_o   (done_clr_o)
   );

   assign init_pend_o = init_flag;

endmodule

// File: tb/serial_word_xcvr_tb.sv
`timescale 1ns/1ps
module serial_word_xcvr_tb;

   localparam int U      = 2;
   localparam int LEAD   = 3 * U;
   localparam int SETUP  = 2 * U;
   localparam int STROBE = U;
   localparam int TAIL   = 3 * U;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid_i = 1'b0, req_tx_i = 1'b0, req_hs_i = 1'b0;
   logic [1:0] req_wsel_i = 2'b00;
   logic [11:0] req_data_i = '0;
   logic mode12_i = 1'b0, dma_i = 1'b0, run_i = 1'b0, init_i = 1'b0;
   logic init_clr_i = 1'b0, datai_i = 1'b0;
   logic busy_o, rsp_valid_o, rsp_abort_o, init_pend_o;
   logic datao_o, shift_o, out_o, trq_o, done_clr_o;
   logic [11:0] rsp_data_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit summary_done = 1'b0;

   // expected line tuple: busy out shift datao trq dclr rvalid rabort
   logic [7:0] exp_q[$];
   logic       din_q[$];

   always #4 clk = ~clk;

   serial_word_xcvr #(.UNIT_CYC(U)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid_i), .req_tx_i(req_tx_i), .req_hs_i(req_hs_i),
      .req_wsel_i(req_wsel_i), .req_data_i(req_data_i),
      .mode12_i(mode12_i), .dma_i(dma_i), .run_i(run_i), .init_i(init_i),
      .init_clr_i(init_clr_i), .datai_i(datai_i),
      .busy_o(busy_o), .rsp_valid_o(rsp_valid_o), .rsp_abort_o(rsp_abort_o),
      .rsp_data_o(rsp_data_o), .init_pend_o(init_pend_o),
      .datao_o(datao_o), .shift_o(shift_o), .out_o(out_o), .trq_o(trq_o),
      .done_clr_o(done_clr_o)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic void add(input int n, input logic [7:0] v, input logic d);
      for (int k = 0; k < n; k++) begin
         exp_q.push_back(v);
         din_q.push_back(d);
      end
   endfunction

   function automatic logic [7:0] lines();
      return {busy_o, out_o, shift_o, datao_o, trq_o, done_clr_o, rsp_valid_o, rsp_abort_o};
   endfunction

   // run_d < 0: a RUN edge is already pending; init_at/poke_at < 0: unused
   task automatic xfer(input bit tx, input bit hs, input logic [1:0] wsel,
                       input logic [11:0] data, input int run_d, input int init_at,
                       input int poke_at, input bit pre_abort, input string tag);
      int w;
      int run_idx;
      logic [11:0] expw;
      run_idx = -1;
      exp_q.delete();
      din_q.delete();
      case (wsel)
         2'b00:   w = mode12_i ? 12 : 8;
         2'b01:   w = 8;
         2'b10:   w = 12;
         default: w = (mode12_i || dma_i) ? 12 : 8;
      endcase
      expw = '0;
      if (pre_abort) begin
         add(1, 8'h03, 1'b0);
      end else begin
         if (tx) begin
            add(LEAD, 8'hC0, 1'b0);
            for (int k = w - 1; k >= 0; k--) begin
               add(SETUP,  {3'b110, data[k], 4'b0000}, 1'b0);
               add(STROBE, {3'b111, data[k], 4'b0000}, 1'b0);
            end
            add(TAIL, {3'b110, data[0], 4'b0000}, 1'b0);
            if (hs) begin
               if (run_d >= 0) run_idx = exp_q.size() + run_d;
               add((run_d < 0) ? 1 : run_d + 4, 8'hC8, 1'b0);
            end
         end else begin
            add(1, 8'h84, 1'b0);
            if (hs) begin
               if (run_d >= 0) run_idx = exp_q.size() + run_d;
               add((run_d < 0) ? 1 : run_d + 4, 8'h88, 1'b0);
            end
            for (int k = w - 1; k >= 0; k--) begin
               add(SETUP,  8'h80, data[k]);
               add(STROBE, 8'hA0, ~data[k]);
            end
            expw = (w == 12) ? data : {4'b0000, data[7:0]};
         end
         if (init_at >= 0) begin
            while (exp_q.size() > init_at + 4) begin
               void'(exp_q.pop_back());
               void'(din_q.pop_back());
            end
            add(1, 8'h03, 1'b0);
            expw = '0;
         end else begin
            add(1, 8'h02, 1'b0);
         end
      end
      add(1, 8'h00, 1'b0);

      req_valid_i = 1'b1;
      req_tx_i    = tx;
      req_hs_i    = hs;
      req_wsel_i  = wsel;
      req_data_i  = data;
      for (int i = 0; i < exp_q.size(); i++) begin
         @(posedge clk);
         @(negedge clk);
         if (i == 0) req_valid_i = 1'b0;
         check(lines() == exp_q[i], tag, 32'(lines()), 32'(exp_q[i]));
         if (exp_q[i][1])
            check(rsp_data_o == expw, {tag, " data"}, 32'(rsp_data_o), 32'(expw));
         datai_i = din_q[i];
         if (i == run_idx) run_i = 1'b1;
         if (run_idx >= 0 && i == run_idx + 3) run_i = 1'b0;
         if (i == init_at) init_i = 1'b1;
         if (i == poke_at) begin
            req_valid_i = 1'b1;
            req_tx_i    = ~tx;
            req_data_i  = ~data;
         end else if (poke_at >= 0 && i == poke_at + 1) begin
            req_valid_i = 1'b0;
         end
      end
      run_i       = 1'b0;
      init_i      = 1'b0;
      req_valid_i = 1'b0;
      datai_i     = 1'b0;
      repeat (6) @(negedge clk);
      check(lines() == 8'h00, {tag, " settle"}, 32'(lines()), 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check({lines(), datao_o, init_pend_o} == 10'h0, "R11 reset outputs",
            32'({lines(), init_pend_o}), 32'h0);

      // R1 R3 R4 R9 wide transmit from the mode pin
      mode12_i = 1'b1;
      xfer(1'b1, 1'b0, 2'b00, 12'hA5C, -1, -1, -1, 1'b0, "R1 R3 R4 tx wide");
      // R1 narrow transmit from the mode pin
      mode12_i = 1'b0;
      xfer(1'b1, 1'b0, 2'b00, 12'h3B6, -1, -1, -1, 1'b0, "R1 tx narrow");
      // R5 R9 wide receive
      mode12_i = 1'b1;
      xfer(1'b0, 1'b0, 2'b00, 12'h5A3, -1, -1, -1, 1'b0, "R5 R1 rx wide");
      // R2 forced narrow while the mode pin says wide
      xfer(1'b0, 1'b0, 2'b01, 12'hFC7, -1, -1, -1, 1'b0, "R2 rx forced narrow");
      // R2 forced wide while the mode pin says narrow
      mode12_i = 1'b0;
      xfer(1'b1, 1'b0, 2'b10, 12'h69E, -1, -1, -1, 1'b0, "R2 tx forced wide");
      // R2 command rule: DMA selects wide, then neither selects narrow
      dma_i = 1'b1;
      xfer(1'b0, 1'b0, 2'b11, 12'hB1D, -1, -1, -1, 1'b0, "R2 rx command dma");
      dma_i = 1'b0;
      xfer(1'b0, 1'b0, 2'b11, 12'h0E2, -1, -1, -1, 1'b0, "R2 rx command narrow");
      // R6 handshake before a receive and after a transmit
      mode12_i = 1'b1;
      xfer(1'b0, 1'b1, 2'b00, 12'h9C4, 5, -1, -1, 1'b0, "R6 rx handshake");
      xfer(1'b1, 1'b1, 2'b00, 12'h3E1, 3, -1, -1, 1'b0, "R6 R4 tx handshake");
      // R7 RUN edge seen early is held, then consumed
      run_i = 1'b1;
      repeat (3) @(negedge clk);
      run_i = 1'b0;
      repeat (6) @(negedge clk);
      xfer(1'b0, 1'b1, 2'b10, 12'h7A8, -1, -1, -1, 1'b0, "R7 pending run");
      xfer(1'b1, 1'b1, 2'b01, 12'h0C3, 2, -1, -1, 1'b0, "R7 run consumed");
      // R10 request during a word is ignored
      xfer(1'b1, 1'b0, 2'b10, 12'h5F0, -1, -1, 10, 1'b0, "R10 busy ignore");
      // R8 INIT aborts a transmit mid word
      xfer(1'b1, 1'b0, 2'b10, 12'hD2B, -1, 20, -1, 1'b0, "R8 init abort");
      check(init_pend_o == 1'b1, "R8 init pending", 32'(init_pend_o), 32'h1);
      xfer(1'b1, 1'b0, 2'b10, 12'h111, -1, -1, -1, 1'b1, "R8 refused");
      init_clr_i = 1'b1;
      @(negedge clk);
      init_clr_i = 1'b0;
      check(init_pend_o == 1'b0, "R8 init cleared", 32'(init_pend_o), 32'h0);
      xfer(1'b0, 1'b0, 2'b10, 12'h3C5, -1, -1, -1, 1'b0, "R8 after clear");

      if (!summary_done) begin
         summary_done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      end
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!summary_done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         summary_done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      end
      $finish;
   end

endmodule